// File: doc/BRIEF.md
# MII Transmit Framer with Underflow Protection

This block takes the bytes of one Ethernet frame at a time from a transmit FIFO and drives a 4-bit MII transmit port. It waits until the FIFO holds enough data and the channel has been granted. It then sends the preamble and start-of-frame nibbles, followed by the frame bytes one nibble per clock, and closes the frame with a computed CRC-32 frame check sequence. The clock is the MII transmit clock, so one nibble leaves on every cycle.

The FIFO side is a valid/ready byte stream. `s_len` is a sideband that gives the byte count of the frame now at the head of the FIFO, from the destination address to the end of the data field, without the FCS. It must hold its value for every byte of that frame. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the source must hold `s_data` and `s_len` steady. `s_ready` depends only on the block's own state, never on `s_valid`. While a frame is being sent, it rises at most once in every two cycles.

A frame whose length is out of range is pulled out of the FIFO without being sent. The FIFO can run dry in the middle of a frame, and the block then ends that frame in a way every receiver will reject. It stops early as a runt, or it closes the frame with a corrupted FCS and TX_ER raised. In both cases it then drains the rest of that frame's bytes from the FIFO.

Top module: `mii_tx_framer`

## Requirements
- R1: A frame starts only when all of these hold in the same idle cycle: `s_valid` is high, `s_len` is in range, `fifo_level >= thresh` and `grant` is high. Until then `tx_en` stays low. Once a frame has started, `grant` and `fifo_level` have no effect on it.
- R2: `tx_en` rises with the first preamble nibble. The preamble is 15 nibbles of 4'h5 followed by one nibble of 4'hD.
- R3: Each frame byte goes out as two nibbles, bits [3:0] first and bits [7:4] second. `tx_en` stays high without a break from the first preamble nibble to the last FCS nibble.
- R4: The FCS is the bitwise complement of a CRC-32 taken over all frame bytes. The CRC starts at all ones and uses the reflected form 32'hEDB88320 of polynomial 32'h04C11DB7. The FCS goes out as 8 nibbles, bits [3:0] first. `tx_er` stays low throughout a frame that has no underflow.
- R5: If `s_len` is below 60 or above 1532 (a total frame of less than 64 or more than 1536 bytes), `tx_en` never rises for that frame. All `s_len` of its bytes are still accepted through the handshake.
- R6: If `s_valid` is low when the next byte is due and fewer than 64 bytes have been sent, the frame is cut: `tx_en` falls at the next nibble and no FCS is sent. The bytes still owed are then drained.
- R7: If the same underflow happens after 64 or more bytes have been sent, the CRC of the bytes sent so far is sent without its complement as the 8 FCS nibbles, with `tx_er` high on all 8. The bytes still owed are then drained.
- R8: Between the end of one frame and the start of the next, `tx_en` stays low for at least 24 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 12 | FIFO fill level needed to start a frame |
| fifo_level | input | 12 | Number of bytes now held in the transmit FIFO |
| grant | input | 1 | Channel access granted |
| s_valid | input | 1 | FIFO byte available |
| s_ready | output | 1 | Block accepts the byte this cycle |
| s_data | input | 8 | FIFO byte |
| s_len | input | 11 | Byte count of the head frame, excluding FCS |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |
| tx_er | output | 1 | MII transmit error |

## Verification
A wrong byte counter or latched length shows up at once. The nibble count between the edges of `tx_en` comes out wrong, or the FIFO read count at the end of a frame differs from `s_len`. A later frame then starts from the wrong byte.

A corrupt CRC register is not visible until the 8 FCS nibbles, so the bench compares every FCS nibble against its own CRC. A wrong underflow decision swaps a 76-nibble runt for a frame closed with a bad FCS, or the reverse. That difference is visible on the first cycle after the FIFO runs dry. A gap timer that is wrong shows up as a short low run of `tx_en` between two frames that are sent back to back.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_DROP,
    ST_GAP
  } mtx_state_e;

  localparam logic [3:0]  PRE_NIB      = 4'h5;
  localparam logic [3:0]  SFD_NIB      = 4'hD;
  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED     = 32'hFFFFFFFF;

  // One byte through the bit-serial reflected CRC-32, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REF) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/mtx_crc32.sv
module mtx_crc32
  import mtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (clear) crc_q <= CRC_SEED;
    else if (take)  crc_q <= crc32_step(crc_q, byte_in);
  end

endmodule

// File: rtl/mtx_len_window.sv
module mtx_len_window #(
  parameter int LEN_W     = 11,
  parameter int MIN_BYTES = 60,
  parameter int MAX_BYTES = 1532
) (
  input  logic [LEN_W-1:0] len,
  output logic             in_range
);

  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_BYTES);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_BYTES);

  assign in_range = (len >= LO) && (len <= HI);

endmodule

// File: rtl/mtx_gap_timer.sv
module mtx_gap_timer #(
  parameter int IFG_NIB = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(IFG_NIB + 1);
  localparam logic [CW-1:0] LAST = CW'(IFG_NIB - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mtx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int LVL_W     = 12,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1536,
  parameter int IFG_NIB   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             grant,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic [LEN_W-1:0] s_len,
  output logic [3:0]       txd,
  output logic             tx_en,
  output logic             tx_er
);

  localparam int FCS_BYTES = 4;
  localparam int MIN_PAY   = MIN_FRAME - FCS_BYTES;
  localparam int MAX_PAY   = MAX_FRAME - FCS_BYTES;
  localparam int PRE_NIBS  = 16;
  localparam int FCS_NIBS  = 2 * FCS_BYTES;
  localparam int NC_W      = $clog2(PRE_NIBS + 1);
  localparam logic [NC_W-1:0]  PRE_LAST = NC_W'(PRE_NIBS - 1);
  localparam logic [NC_W-1:0]  FCS_END  = NC_W'(FCS_NIBS);
  localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(MIN_FRAME);

  mtx_state_e       st;
  logic             phase;
  logic [3:0]       hi_nib;
  logic [LEN_W-1:0] byte_cnt;
  logic [LEN_W-1:0] frm_len;
  logic             bad;
  logic [NC_W-1:0]  nib_cnt;
  logic [31:0]      fcs_sh;

  logic             len_ok;
  logic             bytes_left;
  logic             take;
  logic             start_ok;
  logic             gap_done;
  logic [31:0]      crc_q;
  logic [31:0]      fcs_good;

  mtx_len_window #(
    .LEN_W    (LEN_W),
    .MIN_BYTES(MIN_PAY),
    .MAX_BYTES(MAX_PAY)
  ) u_len (
    .len     (s_len),
    .in_range(len_ok)
  );

  mtx_crc32 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (st == ST_IDLE),
    .take   (take && (st == ST_DATA)),
    .byte_in(s_data),
    .crc_q  (crc_q)
  );

  mtx_gap_timer #(.IFG_NIB(IFG_NIB)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st == ST_GAP),
    .done (gap_done)
  );

  always_comb begin
    bytes_left = (byte_cnt != frm_len);
    s_ready    = (((st == ST_DATA) && !phase) || (st == ST_DROP)) && bytes_left;
    take       = s_valid && s_ready;
    start_ok   = (st == ST_IDLE) && s_valid && len_ok && (fifo_level >= thresh) && grant;
    fcs_good   = ~crc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase    <= 1'b0;
      hi_nib   <= '0;
      byte_cnt <= '0;
      frm_len  <= '0;
      bad      <= 1'b0;
      nib_cnt  <= '0;
      fcs_sh   <= '0;
      txd      <= '0;
      tx_en    <= 1'b0;
      tx_er    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (s_valid && !len_ok) begin
            st       <= ST_DROP;
            frm_len  <= s_len;
            byte_cnt <= '0;
          end else if (start_ok) begin
            st       <= ST_PRE;
            frm_len  <= s_len;
            byte_cnt <= '0;
            bad      <= 1'b0;
            phase    <= 1'b0;
            nib_cnt  <= NC_W'(1);
            tx_en    <= 1'b1;
            txd      <= PRE_NIB;
          end
        end
        ST_PRE: begin
          txd     <= (nib_cnt == PRE_LAST) ? SFD_NIB : PRE_NIB;
          nib_cnt <= nib_cnt + 1'b1;
          if (nib_cnt == PRE_LAST) begin
            st    <= ST_DATA;
            phase <= 1'b0;
          end
        end
        ST_DATA: begin
          if (phase) begin
            txd   <= hi_nib;
            phase <= 1'b0;
          end else if (!bytes_left) begin
            txd     <= fcs_good[3:0];
            fcs_sh  <= {4'h0, fcs_good[31:4]};
            nib_cnt <= NC_W'(1);
            st      <= ST_FCS;
          end else if (s_valid) begin
            txd      <= s_data[3:0];
            hi_nib   <= s_data[7:4];
            byte_cnt <= byte_cnt + 1'b1;
            phase    <= 1'b1;
          end else if (byte_cnt < RUNT_LIM) begin
            // underflow before the minimum size: cut short as a runt
            tx_en <= 1'b0;
            txd   <= '0;
            st    <= ST_DROP;
          end else begin
            // underflow after the minimum size: close with a corrupted FCS
            bad     <= 1'b1;
            tx_er   <= 1'b1;
            txd     <= crc_q[3:0];
            fcs_sh  <= {4'h0, crc_q[31:4]};
            nib_cnt <= NC_W'(1);
            st      <= ST_FCS;
          end
        end
        ST_FCS: begin
          if (nib_cnt == FCS_END) begin
            tx_en <= 1'b0;
            tx_er <= 1'b0;
            txd   <= '0;
            st    <= bytes_left ? ST_DROP : ST_GAP;
          end else begin
            txd     <= fcs_sh[3:0];
            fcs_sh  <= {4'h0, fcs_sh[31:4]};
            nib_cnt <= nib_cnt + 1'b1;
            tx_er   <= bad;
          end
        end
        ST_DROP: begin
          if (take) byte_cnt <= byte_cnt + 1'b1;
          if (!bytes_left) st <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Low-run counter used by the gap check.
  localparam int LR_W = $clog2(IFG_NIB + 1);
  logic [LR_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                         low_run <= LR_W'(IFG_NIB);
    else if (tx_en)                     low_run <= '0;
    else if (low_run != LR_W'(IFG_NIB)) low_run <= low_run + 1'b1;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(grant) && ($past(fifo_level) >= $past(thresh)))); // R1
  AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == PRE_NIB)); // R2
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP) |-> !tx_en); // R5
  AST_ER_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en); // R7
  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (low_run == LR_W'(IFG_NIB))); // R8

endmodule

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;

  localparam int LEN_W = 11;
  localparam int LVL_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] thresh = '0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             grant = 1'b0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic [7:0]       s_data = '0;
  logic [LEN_W-1:0] s_len = '0;
  logic [3:0]       txd;
  logic             tx_en;
  logic             tx_er;

  always #2 clk = ~clk;

  mii_tx_framer i_mii_tx_framer (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .fifo_level(fifo_level),
    .grant(grant), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_len(s_len), .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  int n_chk = 0;
  int n_fail = 0;

  // FIFO model
  logic [7:0] mem [0:2047];
  int rd = 0, avail = 0, len_a = 0, len_b = 0, bound = 2048;
  bit take_q = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (take_q) rd++;
      s_valid    = (rd < avail);
      s_data     = mem[rd % 2048];
      s_len      = LEN_W'((rd < bound) ? len_a : len_b);
      fifo_level = LVL_W'(avail - rd);
      take_q     = s_valid && s_ready;
    end
  end

  // MII monitor
  logic [3:0] cap [0:4095];
  int cap_n = 0, er_n = 0, frames = 0, low_cnt = 0, min_gap = 1000;
  bit prev_en = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (tx_en) begin
        if (!prev_en) begin
          cap_n = 0; er_n = 0;
          if (low_cnt < min_gap) min_gap = low_cnt;
        end
        if (cap_n < 4096) cap[cap_n] = txd;
        cap_n++;
        if (tx_er) er_n++;
        low_cnt = 0;
      end else begin
        low_cnt++;
      end
      if (prev_en && !tx_en) frames++;
      prev_en = tx_en;
    end
  end

  logic [3:0] exp_n [0:4095];
  int exp_len;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int off, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ mem[off + i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    return c;
  endfunction

  // mode 0: good FCS, 1: uncomplemented FCS, 2: no FCS
  task automatic build_exp(input int off, input int n, input int mode);
    logic [31:0] v;
    exp_len = 0;
    for (int i = 0; i < 15; i++) exp_n[exp_len++] = 4'h5;
    exp_n[exp_len++] = 4'hD;
    for (int i = 0; i < n; i++) begin
      exp_n[exp_len++] = mem[off + i][3:0];
      exp_n[exp_len++] = mem[off + i][7:4];
    end
    if (mode != 2) begin
      v = ref_crc(off, n);
      if (mode == 0) v = ~v;
      for (int k = 0; k < 8; k++) exp_n[exp_len++] = v[4*k +: 4];
    end
  endtask

  task automatic cmp_range(input int from, input int to, input string tag);
    int bad = 0, first = -1;
    for (int i = from; i < to; i++) begin
      if (i >= cap_n || cap[i] !== exp_n[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    check(bad == 0, tag, first, -1);
  endtask

  task automatic load(input int off, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[off + i] = 8'((i * 7 + seed * 13 + 3) & 255);
  endtask

  task automatic start_fifo(input int la, input int lb, input int b, input int av);
    @(negedge clk);
    take_q = 0; rd = 0;
    len_a = la; len_b = lb; bound = b; avail = av;
  endtask

  task automatic wait_frame(input int f0);
    int t = 0;
    while (frames == f0 && t < 8000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_rd(input int n);
    int t = 0;
    while (rd < n && t < 8000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!tx_en && !tx_er && !s_ready && txd == 0, "R1 reset idle", {tx_en, tx_er, s_ready}, 0);
  endtask

  task automatic t_normal;
    int f0 = frames;
    load(0, 60, 1);
    thresh = 16; grant = 1;
    start_fifo(60, 60, 2048, 60);
    wait_frame(f0);
    build_exp(0, 60, 0);
    check(cap_n == exp_len, "R3 nibble count 60B", cap_n, exp_len);
    cmp_range(0, 16, "R2 preamble/SFD nibbles");
    cmp_range(16, 136, "R3 data nibble order");
    cmp_range(136, 144, "R4 FCS nibbles");
    check(er_n == 0, "R4 tx_er low on good frame", er_n, 0);
    wait_rd(60);
    check(rd == 60, "R3 bytes consumed", rd, 60);
  endtask

  task automatic t_gate;
    int f0 = frames;
    int t;
    load(0, 80, 2);
    grant = 0; thresh = 16;
    start_fifo(80, 80, 2048, 80);
    repeat (60) @(negedge clk);
    check(frames == f0 && !tx_en, "R1 no start without grant", frames - f0, 0);
    thresh = 100; grant = 1;
    repeat (60) @(negedge clk);
    check(frames == f0 && !tx_en, "R1 no start below threshold", frames - f0, 0);
    thresh = 40;
    t = 0;
    while (!tx_en && t < 200) begin @(negedge clk); t++; end
    grant = 0; // dropping grant mid-frame must not disturb it
    wait_frame(f0);
    build_exp(0, 80, 0);
    check(cap_n == exp_len, "R1 grant ignored once started", cap_n, exp_len);
    cmp_range(0, exp_len, "R1 frame content after gating");
    grant = 1;
    wait_rd(80);
  endtask

  task automatic t_len;
    int f0 = frames;
    load(0, 59, 3);
    thresh = 16;
    start_fifo(59, 59, 2048, 59);
    wait_rd(59);
    check(frames == f0, "R5 short frame not sent", frames - f0, 0);
    check(rd == 59, "R5 short frame drained", rd, 59);
    load(0, 1533, 4);
    start_fifo(1533, 1533, 2048, 1533);
    wait_rd(1533);
    check(frames == f0, "R5 long frame not sent", frames - f0, 0);
    check(rd == 1533, "R5 long frame drained", rd, 1533);
    load(0, 1532, 5);
    start_fifo(1532, 1532, 2048, 1532);
    wait_frame(f0);
    build_exp(0, 1532, 0);
    check(cap_n == exp_len, "R5 max length sent", cap_n, exp_len);
    cmp_range(exp_len - 8, exp_len, "R5 max length FCS");
    wait_rd(1532);
  endtask

  task automatic t_runt;
    int f0 = frames;
    load(0, 100, 6);
    thresh = 10;
    start_fifo(100, 100, 2048, 30);
    wait_frame(f0);
    build_exp(0, 30, 2);
    check(cap_n == exp_len, "R6 runt length", cap_n, exp_len);
    cmp_range(0, exp_len, "R6 runt content");
    check(er_n == 0, "R6 runt without FCS", er_n, 0);
    avail = 100;
    wait_rd(100);
    check(rd == 100 && frames == f0 + 1, "R6 remainder drained", rd, 100);
  endtask

  task automatic t_late;
    int f0 = frames;
    load(0, 100, 7);
    thresh = 10;
    start_fifo(100, 100, 2048, 70);
    wait_frame(f0);
    build_exp(0, 70, 1);
    check(cap_n == exp_len, "R7 length with bad FCS", cap_n, exp_len);
    cmp_range(16, exp_len - 8, "R7 data before underflow");
    cmp_range(exp_len - 8, exp_len, "R7 uncomplemented FCS");
    check(er_n == 8, "R7 tx_er over FCS", er_n, 8);
    avail = 100;
    wait_rd(100);
    check(rd == 100 && frames == f0 + 1, "R7 remainder drained", rd, 100);
  endtask

  task automatic t_ifg;
    int f0 = frames;
    load(0, 60, 8);
    load(60, 64, 9);
    thresh = 16; grant = 1;
    start_fifo(60, 64, 60, 124);
    wait_frame(f0);
    min_gap = 1000;
    wait_frame(f0 + 1);
    check(min_gap >= 24, "R8 inter-frame gap", min_gap, 24);
    build_exp(60, 64, 0);
    check(cap_n == exp_len, "R8 second frame length", cap_n, exp_len);
    cmp_range(0, exp_len, "R8 second frame content");
    wait_rd(124);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_gate();
    t_len();
    t_runt();
    t_late();
    t_ifg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule